// File: doc/BRIEF.md
# Multi-Lane Serial ADC Result Reader

This block sits on the host side of a six-channel, simultaneously sampling ADC that runs in serial mode. On a request it raises the conversion-start line, waits for the converter's BUSY line to rise and then fall, and then opens one read frame. It lowers chip-select for the whole frame, keeps read low the whole time, and generates a serial clock from the system clock with a programmable divide. It shifts in the six 16-bit results on one, two or three data-out lanes. The host chooses the lane count and the block drives the matching lane-select levels to the converter. It holds the daisy-chain enable inactive.

Once the frame closes, the six results leave the block as tagged words on consecutive cycles. A one-cycle done pulse follows them. The frame is three times shorter with three lanes than with one, because every enabled lane carries an equal share of the channels.

The control path is a six-state machine: `ST_IDLE` waits for a request; `ST_CONV` holds conversion-start high until BUSY is seen high; `ST_HOLD` waits for BUSY to fall; `ST_FRAME` runs the serial clock with chip-select low; `ST_EMIT` presents the six words; `ST_DONE` raises the done pulse and returns to `ST_IDLE`. The transitions are IDLE→CONV on a request, CONV→HOLD on BUSY high, HOLD→FRAME on BUSY low, FRAME→EMIT on the rising serial-clock edge after the last bit, EMIT→DONE after tag 5, and DONE→IDLE unconditionally.

Top module: `serial_adc_reader`

## Requirements
- R1: After reset, chip-select and the serial clock are high, conversion-start, word_valid and frame_done are low, lane-select is 3'b001, daisy-chain enable is low and read is low.
- R2: A request taken in the idle state captures cfg_lanes and cfg_div and raises conversion-start in the next cycle. Conversion-start stays high until BUSY is seen high. A request made while a transfer is running has no effect: it starts no further conversion or frame.
- R3: Chip-select falls only after BUSY has been seen low following its high phase. It stays low for the whole frame. Read stays low at all times.
- R4: Lane-select is encoded as bit 0 = lane A, bit 1 = lane B and bit 2 = lane C. cfg_lanes 2'd2 gives 3'b011 (two lanes), 2'd3 gives 3'b111 (three lanes), and any other value gives 3'b001 (one lane). Daisy-chain enable stays low.
- R5: The serial clock idles high. During a frame each high and each low phase lasts cfg_div+1 system-clock cycles. Data is captured at each falling serial-clock edge.
- R6: A frame contains exactly 96/L falling serial-clock edges, where L is the active lane count: 96 for one lane, 48 for two and 32 for three.
- R7: adc_dout bit 0 is lane A, bit 1 is lane B and bit 2 is lane C. Lane k (from 0) carries channels k·(6/L) to k·(6/L)+6/L−1 in ascending order, each 16 bits MSB first. Lanes that are not enabled are ignored.
- R8: After the frame the six results appear on six consecutive cycles with word_valid high. word_tag runs 0 to 5 and equals the channel number minus one.
- R9: frame_done is high for exactly the one cycle that follows the word tagged 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_lanes | input | 2 | Lane count code, captured on request |
| cfg_div | input | DIV_W | Serial-clock half period minus one, in system-clock cycles |
| acq_req | input | 1 | Starts one conversion and readout when idle |
| adc_busy | input | 1 | Converter busy level |
| adc_dout | input | 3 | Serial data lanes A, B, C |
| adc_cnv | output | 1 | Conversion-start level |
| adc_cs_n | output | 1 | Frame chip-select, active low |
| adc_rd_n | output | 1 | Read strobe, held low |
| adc_sclk | output | 1 | Serial clock |
| adc_lane_sel | output | 3 | Lane-select levels C, B, A |
| adc_chain_en | output | 1 | Daisy-chain enable, held low |
| word_valid | output | 1 | Result word present |
| word_tag | output | 3 | Channel tag of the word |
| word_data | output | WORD_W | Result word |
| frame_done | output | 1 | One-cycle pulse after the sixth word |

## Verification
The bench uses the default parameters: 16-bit words and a 4-bit divider field. Its vectors use divides of 0 to 3, so both the fastest serial clock (one system cycle per phase) and slower ones are measured phase by phase. Every lane code is exercised, including the out-of-range code 0, so all three channel-to-lane packings and their frame lengths are covered. Disabled lanes are driven high while the enabled ones carry data, which shows whether the block ignores them.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int LANES    = 3;
    localparam int CHANNELS = 6;
    localparam int TAG_W    = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_HOLD,
        ST_FRAME,
        ST_EMIT,
        ST_DONE
    } srx_state_t;

    // Lane count from the configuration code: 2 and 3 select themselves, rest select 1.
    function automatic logic [1:0] lanes_from_code(input logic [1:0] code);
        logic [1:0] n;
        unique case (code)
            2'd2:    n = 2'd2;
            2'd3:    n = 2'd3;
            default: n = 2'd1;
        endcase
        return n;
    endfunction

    // Words carried per lane for a given lane count.
    function automatic logic [2:0] words_per_lane(input logic [1:0] n);
        logic [2:0] w;
        unique case (n)
            2'd2:    w = 3'd3;
            2'd3:    w = 3'd2;
            default: w = 3'd6;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/srx_sclk_gen.sv
module srx_sclk_gen #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             sclk,
    output logic             fall,
    output logic             rise
);
    logic [DIV_W-1:0] cnt_q;
    logic             sclk_q;
    logic             flip;

    assign flip = run && (cnt_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (!run) begin
            cnt_q  <= '0;
            sclk_q <= 1'b1;
        end else if (flip) begin
            cnt_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sclk = sclk_q;
    assign fall = flip && sclk_q;
    assign rise = flip && !sclk_q;

    // R5: a phase never ends before its count is reached
    p_phase_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && (sclk_q != $past(sclk_q))) |-> ($past(cnt_q) == $past(div)));
endmodule

// File: rtl/srx_lane.sv
module srx_lane #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              din,
    output logic [WORD_W-1:0] word_next
);
    logic [WORD_W-2:0] sh_q;

    assign word_next = {sh_q, din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (clr) begin
            sh_q <= '0;
        end else if (shift) begin
            sh_q <= word_next[WORD_W-2:0];
        end
    end
endmodule

// File: rtl/serial_adc_reader.sv
module serial_adc_reader
    import srx_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_lanes,
    input  logic [DIV_W-1:0]     cfg_div,
    input  logic                 acq_req,
    input  logic                 adc_busy,
    input  logic [LANES-1:0]     adc_dout,
    output logic                 adc_cnv,
    output logic                 adc_cs_n,
    output logic                 adc_rd_n,
    output logic                 adc_sclk,
    output logic [LANES-1:0]     adc_lane_sel,
    output logic                 adc_chain_en,
    output logic                 word_valid,
    output logic [TAG_W-1:0]     word_tag,
    output logic [WORD_W-1:0]    word_data,
    output logic                 frame_done
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(CHANNELS - 1);

    srx_state_t        state_q, state_d;
    logic [1:0]        lanes_q;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;
    logic [2:0]        word_q;
    logic [TAG_W-1:0]  emit_q;
    logic [2:0]        wpl;
    logic              sclk_run, sclk_fall, sclk_rise;
    logic              word_end, frame_end;
    logic [WORD_W-1:0] lane_next [LANES];
    logic [WORD_W-1:0] bank_q    [CHANNELS];

    assign wpl       = words_per_lane(lanes_q);
    assign sclk_run  = (state_q == ST_FRAME);
    assign word_end  = sclk_fall && (bit_q == LAST_BIT);
    assign frame_end = sclk_rise && (word_q == wpl);

    srx_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sclk_run),
        .div  (div_q),
        .sclk (adc_sclk),
        .fall (sclk_fall),
        .rise (sclk_rise)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        srx_lane #(.WORD_W(WORD_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (!sclk_run),
            .shift    (sclk_fall),
            .din      (adc_dout[g]),
            .word_next(lane_next[g])
        );
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (acq_req)          state_d = ST_CONV;
            ST_CONV:  if (adc_busy)         state_d = ST_HOLD;
            ST_HOLD:  if (!adc_busy)        state_d = ST_FRAME;
            ST_FRAME: if (frame_end)        state_d = ST_EMIT;
            ST_EMIT:  if (emit_q == LAST_TAG) state_d = ST_DONE;
            ST_DONE:                        state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // Configuration capture, bit and word counters, result bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lanes_q <= 2'd1;
            div_q   <= '0;
            bit_q   <= '0;
            word_q  <= '0;
            emit_q  <= '0;
            for (int c = 0; c < CHANNELS; c++) bank_q[c] <= '0;
        end else begin
            if (state_q == ST_IDLE && acq_req) begin
                lanes_q <= lanes_from_code(cfg_lanes);
                div_q   <= cfg_div;
            end
            if (!sclk_run) begin
                bit_q  <= '0;
                word_q <= '0;
            end else if (sclk_fall) begin
                if (bit_q == LAST_BIT) begin
                    bit_q  <= '0;
                    word_q <= word_q + 3'd1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
            // R7: lane k fills slots k*wpl .. k*wpl+wpl-1
            for (int l = 0; l < LANES; l++) begin
                if (word_end && (2'(l) < lanes_q)) begin
                    bank_q[3'(l) * wpl + word_q] <= lane_next[l];
                end
            end
            if (state_q == ST_EMIT && emit_q != LAST_TAG) emit_q <= emit_q + 1'b1;
            else                                          emit_q <= '0;
        end
    end

    // Outputs
    always_comb begin
        adc_cnv    = 1'b0;
        adc_cs_n   = 1'b1;
        word_valid = 1'b0;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_CONV:  adc_cnv    = 1'b1;
            ST_HOLD:  ;
            ST_FRAME: adc_cs_n   = 1'b0;
            ST_EMIT:  word_valid = 1'b1;
            ST_DONE:  frame_done = 1'b1;
            default:  ;
        endcase
    end

    assign adc_rd_n     = 1'b0;
    assign adc_chain_en = 1'b0;
    assign adc_lane_sel = {lanes_q == 2'd3, lanes_q >= 2'd2, 1'b1};
    assign word_tag     = emit_q;
    assign word_data    = bank_q[emit_q];

    // R4: lane C is never enabled without lane B
    p_sel_nested_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_lane_sel[2] |-> adc_lane_sel[1]);

    // R5: the serial clock rests high outside a frame
    p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    // R3: the frame opens only once BUSY was low
    p_cs_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $past(!adc_busy));

    // R8: tags stay within the six channels
    p_tag_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (word_tag <= LAST_TAG));

    // R8: tags advance by one on consecutive cycles
    p_tag_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && word_tag != '0) |-> ($past(word_valid) && ($past(word_tag) == word_tag - 1'b1)));

    // R9: the done pulse directly follows the last word
    p_done_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(word_valid && word_tag == LAST_TAG));
endmodule

// File: tb/test_serial_adc_reader.sv
`timescale 1ns/1ps
module test_serial_adc_reader;
    localparam int WORD_W = 16;
    localparam int DIV_W  = 4;
    localparam int NVEC   = 6;

    // {lane code, divide, ch1 .. ch6}
    localparam logic [101:0] VECS [NVEC] = '{
        {2'd1, 4'd0, 16'hA5C3, 16'h0001, 16'h8000, 16'hFFFF, 16'h1234, 16'h7E81},
        {2'd2, 4'd1, 16'h0F0F, 16'hF0F0, 16'h5555, 16'hAAAA, 16'h8001, 16'h3C3C},
        {2'd3, 4'd2, 16'hDEAD, 16'hBEEF, 16'h0000, 16'hFFFF, 16'h6B2D, 16'h9124},
        {2'd0, 4'd1, 16'h4C1E, 16'h0002, 16'hC000, 16'h7FFF, 16'h1357, 16'h2468},
        {2'd3, 4'd0, 16'h8421, 16'h1248, 16'hFEDC, 16'h0123, 16'hA0A0, 16'h0505},
        {2'd2, 4'd3, 16'h7001, 16'h0E00, 16'h00F0, 16'h000F, 16'h9999, 16'h6666}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        cfg_lanes;
    logic [DIV_W-1:0]  cfg_div;
    logic              acq_req;
    logic              adc_busy = 1'b0;
    logic [2:0]        adc_dout;
    logic              adc_cnv, adc_cs_n, adc_rd_n, adc_sclk, adc_chain_en;
    logic [2:0]        adc_lane_sel;
    logic              word_valid, frame_done;
    logic [2:0]        word_tag;
    logic [WORD_W-1:0] word_data;

    always #4 clk = ~clk;

    serial_adc_reader #(.WORD_W(WORD_W), .DIV_W(DIV_W)) i_serial_adc_reader (
        .clk(clk), .rst_n(rst_n), .cfg_lanes(cfg_lanes), .cfg_div(cfg_div),
        .acq_req(acq_req), .adc_busy(adc_busy), .adc_dout(adc_dout),
        .adc_cnv(adc_cnv), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .adc_sclk(adc_sclk), .adc_lane_sel(adc_lane_sel), .adc_chain_en(adc_chain_en),
        .word_valid(word_valid), .word_tag(word_tag), .word_data(word_data),
        .frame_done(frame_done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Converter model state
    logic [15:0] cur_words [6];
    int          cur_l   = 1;
    int          cur_div = 0;

    // Monitor state
    int          falls = 0, last_falls = 0, run_len = 0;
    logic        prev_sclk = 1'b1, in_frame = 1'b0, busy_at_open = 1'b0;
    int          frame_cnt = 0, done_cnt = 0, half_err = 0, order_err = 0, fixed_err = 0;
    int          nwords = 0, cyc = 0, last_word_cyc = 0, done_cyc = 0;
    logic [15:0] got [6];

    // BUSY model: rises two cycles after conversion-start, falls 20 cycles later
    always begin
        @(posedge adc_cnv);
        repeat (2) @(posedge clk);
        #1 adc_busy = 1'b1;
        repeat (20) @(posedge clk);
        #1 adc_busy = 1'b0;
    end

    // Serial data model: MSB at frame open, next bit after each rising serial clock
    always_comb begin
        int idx;
        idx = adc_sclk ? falls : falls - 1;
        for (int l = 0; l < 3; l++) begin
            if (l < cur_l && idx >= 0 && idx < 96 / cur_l)
                adc_dout[l] = cur_words[l * (6 / cur_l) + idx / 16][15 - idx % 16];
            else
                adc_dout[l] = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_rd_n !== 1'b0 || adc_chain_en !== 1'b0) fixed_err++;
            if (!adc_cs_n) begin
                if (!in_frame) begin
                    in_frame     = 1'b1;
                    frame_cnt++;
                    busy_at_open = adc_busy;
                    run_len      = 1;
                    prev_sclk    = adc_sclk;
                    falls        = 0;
                end else if (adc_sclk == prev_sclk) begin
                    run_len++;
                end else begin
                    if (run_len != cur_div + 1) half_err++;
                    if (prev_sclk && !adc_sclk) falls++;
                    run_len   = 1;
                    prev_sclk = adc_sclk;
                end
            end else begin
                if (in_frame) last_falls = falls;
                in_frame = 1'b0;
                falls    = 0;
                nwords   = word_valid ? nwords : (frame_done ? nwords : nwords);
            end
            if (word_valid) begin
                got[word_tag] = word_data;
                if (int'(word_tag) != nwords % 6) order_err++;
                nwords++;
                last_word_cyc = cyc;
            end
            if (frame_done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            cyc++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lanes_of(input logic [1:0] code);
        return (code == 2'd2) ? 2 : (code == 2'd3) ? 3 : 1;
    endfunction

    task automatic run_transfer(input logic [101:0] v, input bit poke_midway);
        int d0, f0, h0, o0, l;
        logic [2:0] exp_sel;
        l = lanes_of(v[101:100]);
        for (int c = 0; c < 6; c++) cur_words[c] = v[95 - 16 * c -: 16];
        cur_l   = l;
        cur_div = int'(v[99:96]);
        d0 = done_cnt; f0 = frame_cnt; h0 = half_err; o0 = order_err;
        @(posedge clk); #1;
        cfg_lanes = v[101:100]; cfg_div = v[99:96]; acq_req = 1'b1;
        @(posedge clk); #1 acq_req = 1'b0;
        @(negedge clk);
        check(adc_cnv === 1'b1, "R2", "conversion start after request", adc_cnv, 1);
        if (poke_midway) begin
            while (adc_cs_n) @(negedge clk);
            @(posedge clk); #1;
            cfg_lanes = 2'd1; cfg_div = 4'd0; acq_req = 1'b1;
            @(posedge clk); #1 acq_req = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        exp_sel = (l == 3) ? 3'b111 : (l == 2) ? 3'b011 : 3'b001;
        check(adc_lane_sel === exp_sel, "R4", "lane select", adc_lane_sel, exp_sel);
        check(busy_at_open === 1'b0 && frame_cnt == f0 + 1, "R3", "frame opened after busy low",
              {busy_at_open, 8'(frame_cnt - f0)}, 1);
        check(half_err == h0, "R5", "serial clock phase length errors", half_err - h0, 0);
        check(last_falls == 96 / l, "R6", "falling edges per frame", last_falls, 96 / l);
        for (int c = 0; c < 6; c++)
            check(got[c] === cur_words[c], "R7", $sformatf("channel %0d word", c + 1), got[c], cur_words[c]);
        check(order_err == o0, "R8", "tag order errors", order_err - o0, 0);
        check(done_cyc == last_word_cyc + 1, "R9", "done cycle after last word",
              done_cyc - last_word_cyc, 1);
    endtask

    task automatic run_all();
        int d0, f0;
        // R1: reset state
        @(negedge clk);
        check(adc_cs_n === 1'b1 && adc_sclk === 1'b1, "R1", "cs_n/sclk in reset", {adc_cs_n, adc_sclk}, 2'b11);
        check(adc_cnv === 1'b0 && word_valid === 1'b0 && frame_done === 1'b0, "R1", "cnv/valid/done in reset",
              {adc_cnv, word_valid, frame_done}, 0);
        check(adc_lane_sel === 3'b001 && adc_chain_en === 1'b0 && adc_rd_n === 1'b0, "R1",
              "sel/chain/rd in reset", {adc_lane_sel, adc_chain_en, adc_rd_n}, 5'b00100);
        @(posedge clk); #1 rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++) run_transfer(VECS[v], 1'b0);

        // R2: a request during a frame is ignored
        d0 = done_cnt; f0 = frame_cnt;
        run_transfer({2'd3, 4'd1, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 16'h5555, 16'h6666}, 1'b1);
        repeat (200) @(negedge clk);
        check(frame_cnt == f0 + 1 && done_cnt == d0 + 1, "R2", "frames after request in frame",
              frame_cnt - f0, 1);
        check(adc_cs_n === 1'b1 && adc_cnv === 1'b0, "R2", "idle after ignored request",
              {adc_cs_n, adc_cnv}, 2'b10);
        check(fixed_err == 0, "R3", "rd_n or chain enable left low level", fixed_err, 0);
    endtask

    initial begin
        bit timeout;
        timeout   = 1'b0;
        rst_n     = 1'b0;
        acq_req   = 1'b0;
        cfg_lanes = 2'd0;
        cfg_div   = '0;
        for (int c = 0; c < 6; c++) cur_words[c] = '0;
        repeat (3) @(posedge clk);
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        disable fork;
        if (timeout) check(1'b0, "R1", "watchdog expired", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule